// File: doc/BRIEF.md
# Half-Full Triggered Block Sender

This block takes in a stream of words, one per clock at most and at any time, and sends them out again in blocks of fixed length. The words are held in an internal circular buffer whose depth is twice the block length. Nothing is read while the buffer holds fewer than one block's worth of words. When the buffer reaches half occupancy, a small word counter takes over and reads exactly one block, one word per clock. It marks the first word and the last word of the block. Writes keep being accepted while the block is being sent.

When a block finishes and at least one more block's worth of words is already waiting, the next block follows on the very next cycle. The status side of the block reports the current occupancy. It also has a sticky overflow bit that is set if a write ever meets a full buffer.

Top module: `blk_burst_sender`

## Requirements
- R1: Reset (`rst` high, sampled on the rising clock edge) empties the buffer and idles the sender: `occupancy` reads 0 and `out_valid`, `out_sob`, `out_eob` and `overflow` read 0. Words written before the reset are never sent.
- R2: Every accepted word leaves on `out_data` exactly once and in write order. The read and write positions wrap modulo the depth, so order holds across any number of wraps.
- R3: While no block is in progress and `occupancy` shows fewer than BLOCK_LEN words, no beat is produced: `out_valid` stays 0 in the following cycle.
- R4: When no block is in progress and `occupancy` shows at least BLOCK_LEN (half of the depth 2*BLOCK_LEN), a block starts. Its first beat is on the output port one clock later, with `out_sob` = 1.
- R5: A block is exactly BLOCK_LEN beats on consecutive cycles and cannot be interrupted. `out_sob` is 1 only on the first beat and `out_eob` is 1 only on the last beat.
- R6: If `occupancy` is still at least BLOCK_LEN in the cycle that shows the `out_eob` beat, the next block's first beat (`out_sob` = 1) follows in the very next cycle, with no idle gap.
- R7: A write is accepted in any cycle in which the buffer is not full, including during a block. A write and a read in the same cycle leave `occupancy` unchanged. `occupancy` shows the word count one clock after the edge that changed it.
- R8: A write that meets a full buffer is dropped and sets `overflow`, which stays 1 until reset. Because a read runs every cycle whenever the buffer is at least half full, a producer writing at most one word per cycle never raises `occupancy` above BLOCK_LEN, so `overflow` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer presents a word this cycle |
| in_data | input | DATA_W | Producer word |
| out_valid | output | 1 | Output beat valid (registered) |
| out_data | output | DATA_W | Output word (registered) |
| out_sob | output | 1 | First beat of a block |
| out_eob | output | 1 | Last beat of a block |
| occupancy | output | $clog2(2*BLOCK_LEN+1) | Words currently held |
| overflow | output | 1 | Sticky: a write met a full buffer |

## Verification
The bench goes after the threshold edge: occupancy one below the block length, then exactly at it. A design with an off-by-one compare would start early or stall one word short. Long runs of continuous writes force back-to-back blocks. A sender that returns to idle for a cycle between blocks would show a gap, and one that counts the wrong number of beats would misplace `out_eob`. Mixed write patterns wrap the pointers many times, where a broken wrap corrupts order or drops words. A reset in the middle of a run checks that leftover words are discarded and do not count towards the next half-full start.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  // Beat position markers carried alongside each output word.
  typedef struct packed {
    logic sob;
    logic eob;
  } bbs_mark_t;
endpackage

// File: rtl/bbs_store.sv
// Circular word storage: one write port, one registered read port,
// written so that a block RAM can be inferred.
module bbs_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/bbs_occ.sv
// Pointer and occupancy tracking, write acceptance and sticky overflow.
module bbs_occ #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop,
  output logic             push_ok,
  output logic [AW-1:0]    wr_ptr,
  output logic [AW-1:0]    rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);

  logic          full;
  logic [AW-1:0] wr_nxt;
  logic [AW-1:0] rd_nxt;

  assign full    = (count == FULL_CNT);
  assign push_ok = push_req && !full;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_cmp_wrap
      assign wr_nxt = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_nxt;
      if (pop)     rd_ptr <= rd_nxt;
      case ({push_ok, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_req && full) overflow <= 1'b1;
    end
  end

  // R7
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  // R7
  occ_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push_req && pop && !full) |=> (count == $past(count)));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
endmodule

// File: rtl/bbs_burst.sv
// Block word counter: decides when to read and marks block boundaries.
module bbs_burst #(
  parameter int BLOCK_LEN = 8,
  parameter int CNT_W     = 5,
  parameter int BW        = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count,
  output logic             pop,
  output logic             first,
  output logic             last
);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(BLOCK_LEN);
  localparam logic [BW-1:0]    END_IDX  = BW'(BLOCK_LEN - 1);

  logic [BW-1:0] idx;
  logic          running;

  assign running = (idx != '0);
  assign pop     = running || (count >= HALF_CNT);
  assign first   = pop && !running;
  assign last    = pop && (idx == END_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (pop) begin
      idx <= last ? '0 : idx + 1'b1;
    end
  end

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
endmodule

// File: rtl/blk_burst_sender.sv
module blk_burst_sender
  import bbs_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BLOCK_LEN = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 in_valid,
  input  logic [DATA_W-1:0]                    in_data,
  output logic                                 out_valid,
  output logic [DATA_W-1:0]                    out_data,
  output logic                                 out_sob,
  output logic                                 out_eob,
  output logic [$clog2(2*BLOCK_LEN+1)-1:0]     occupancy,
  output logic                                 overflow
);
  localparam int DEPTH = 2 * BLOCK_LEN;
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int BW    = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(BLOCK_LEN);

  logic             push_ok;
  logic             pop;
  logic             first;
  logic             last;
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic [CNT_W-1:0] count;
  bbs_mark_t        mark_q;

  bbs_occ #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) occ_i (
    .clk      (clk),
    .rst      (rst),
    .push_req (in_valid),
    .pop      (pop),
    .push_ok  (push_ok),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .count    (count),
    .overflow (overflow)
  );

  bbs_burst #(.BLOCK_LEN(BLOCK_LEN), .CNT_W(CNT_W), .BW(BW)) burst_i (
    .clk   (clk),
    .rst   (rst),
    .count (count),
    .pop   (pop),
    .first (first),
    .last  (last)
  );

  bbs_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) store_i (
    .clk     (clk),
    .wr_en   (push_ok),
    .wr_addr (wr_ptr),
    .wr_data (in_data),
    .rd_en   (pop),
    .rd_addr (rd_ptr),
    .rd_data (out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      mark_q    <= '0;
    end else begin
      out_valid <= pop;
      mark_q    <= '{sob: first, eob: last};
    end
  end

  assign out_sob   = mark_q.sob;
  assign out_eob   = mark_q.eob;
  assign occupancy = count;

  // R5
  sob_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_sob);

  // R5
  mid_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_eob) |=> (out_valid && !out_sob));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((!out_valid || out_eob) && (occupancy < HALF_CNT)) |=> !out_valid);

  // R4
  half_start_chk: assert property (@(posedge clk) disable iff (rst)
    ((!out_valid || out_eob) && (occupancy >= HALF_CNT)) |=> (out_valid && out_sob));
endmodule

// File: tb/blk_burst_sender_tb_top.sv
module blk_burst_sender_tb_top;
  localparam int DW    = 16;
  localparam int BL    = 4;
  localparam int DEPTH = 2 * BL;
  localparam int OW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          out_sob;
  logic          out_eob;
  logic [OW-1:0] occupancy;
  logic          overflow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state built from the requirements
  logic [DW-1:0] exp_q[$];
  int  mocc = 0;
  int  mcnt = 0;
  bit  mover = 1'b0;
  bit  prev_eob = 1'b0;
  logic [DW-1:0] seed = 16'h0100;

  always #10 clk = ~clk;  // 20-unit period: 50 MHz

  blk_burst_sender #(.DATA_W(DW), .BLOCK_LEN(BL)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sob   (out_sob),
    .out_eob   (out_eob),
    .occupancy (occupancy),
    .overflow  (overflow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected words as beats appear (R2)
  always @(posedge clk) begin
    #2;
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "beat with nothing expected", int'(out_data), -1);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(out_data == e, "R2", "word order", int'(out_data), int'(e));
      end
    end
  end

  // driver: one clock of stimulus, called at a falling edge
  task automatic step(input bit v, input logic [DW-1:0] d);
    bit pop, first, last, acc;
    string tag;
    in_valid = v;
    in_data  = d;
    pop   = (mcnt != 0) || (mocc >= BL);
    first = pop && (mcnt == 0);
    last  = pop && (mcnt == BL - 1);
    acc   = v && (mocc != DEPTH);
    if (acc) exp_q.push_back(d);
    if (v && !acc) mover = 1'b1;
    mocc = mocc + int'(acc) - int'(pop);
    if (pop) mcnt = last ? 0 : mcnt + 1;
    @(negedge clk);
    if (!pop)                  tag = "R3";
    else if (first && prev_eob) tag = "R6";
    else if (first)            tag = "R4";
    else                       tag = "R5";
    check(out_valid == pop, tag, "out_valid", int'(out_valid), int'(pop));
    if (pop) begin
      check(out_sob == first, "R5", "out_sob", int'(out_sob), int'(first));
      check(out_eob == last, "R5", "out_eob", int'(out_eob), int'(last));
    end
    check(int'(occupancy) == mocc, "R7", "occupancy", int'(occupancy), mocc);
    check(overflow == mover, "R8", "overflow", int'(overflow), int'(mover));
    prev_eob = pop && last;
  endtask

  task automatic write_n(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b1, seed);
      seed = seed + 16'd1;
    end
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
    mocc = 0; mcnt = 0; mover = 1'b0; prev_eob = 1'b0;
    // R1
    check(occupancy == '0, "R1", "occupancy after reset", int'(occupancy), 0);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(out_sob == 1'b0 && out_eob == 1'b0, "R1", "markers after reset",
          int'({out_sob, out_eob}), 0);
    check(overflow == 1'b0, "R1", "overflow after reset", int'(overflow), 0);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // one below half: nothing sent (R3)
    write_n(BL - 1);
    idle_n(3);
    // reaching half starts one block (R4, R5)
    write_n(1);
    idle_n(BL + 3);
    // continuous writes: back-to-back blocks, writes during blocks (R6, R7)
    write_n(40);
    idle_n(2 * BL + 2);
    // bursty pattern: two writes then one idle, wrapping pointers (R2)
    for (int k = 0; k < 20; k++) begin
      write_n(2);
      idle_n(1);
    end
    idle_n(2 * BL + 2);
    // reset mid-stream discards held words (R1)
    write_n(BL + 2);
    do_reset();
    write_n(BL - 1);
    idle_n(4);
    write_n(BL + 1);
    idle_n(3 * BL);
    // R2: every accepted word still held is accounted for
    check(exp_q.size() == mocc, "R2", "words left vs occupancy",
          exp_q.size(), mocc);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule